// File: doc/BRIEF.md
# PHY Management Access Port

This block puts one 32-bit host-visible word in front of the management interface of an external PHY. Software writes the word to start a transfer. The block turns the request into a serial management frame on MDC and MDIO, using a PHY address fixed by a parameter. It then reports completion in the top bit of the same word.

A request with bit 31 set is a register write. The flag reads 1 while the write is in flight and drops to 0 once the frame has been clocked out. A request with bit 31 clear is a register read. The flag reads 0 while the frame runs and rises to 1 when the sixteen returned bits have been placed in the low half of the word. The two directions therefore signal completion with opposite polarity, and software must poll accordingly.

The host side is a plain register port: a one-cycle write strobe with a data word, and a read-back word that is always valid. There is no back-pressure. A write strobe that arrives while a frame is running is dropped, and software is expected to poll the flag before issuing the next request. MDC is produced by dividing the system clock. It idles low whenever no frame is running.

Top module: `phy_mgmt_port`

## Requirements
- R1: After reset the access word reads 0, MDC is low and the MDIO output enable is low.
- R2: A request with bit 31 = 1 starts a write. From the cycle after the strobe until the frame ends, bit 31 reads 1. Afterwards it reads 0, and bits 23:0 keep the value that was written.
- R3: A request with bit 31 = 0 starts a read. Bit 31 reads 0 until the frame ends. Afterwards bit 31 reads 1, and bits 15:0 hold the 16 bits sampled from MDIO.
- R4: Bits 30:24 of a request are discarded and always read 0. The 8-bit field in bits 23:16 reads back as written, and only bits 20:16 of it become the 5-bit register field of the frame.
- R5: A write frame is 64 MDC cycles, sent MSB first with the output enable high throughout. It consists of 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register field, turnaround 10, then the 16 data bits.
- R6: A read frame uses opcode 10 and is otherwise the same through the register field. The output enable drops from the first turnaround bit (bit 46) to the end of the frame. MDIO is sampled on the rising MDC edge of each of bits 48 to 63, MSB first.
- R7: MDIO out changes only while MDC is low, never at a rising MDC edge.
- R8: MDC has a period of 2*MDC_HALF system clocks while a frame runs, and it is held low when idle.
- R9: A host write strobe that arrives while a frame is in progress has no effect on the access word or on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle write strobe for the access word |
| host_wdata | input | 32 | Request word: bit 31 direction, 23:16 register, 15:0 data |
| host_rdata | output | 32 | Current access word with completion flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO driver |
| mdio_i | input | 1 | Serial data returned from the PHY |

## Verification
The bench sweeps every one of the 32 register-field values in both directions. It uses a behavioural PHY that records each bit on rising MDC and returns a chosen word during the read data phase. Expected frames are built arithmetically from the request.

The checks target the following faults, each by its visible symptom:

- Inverted flag polarity on one direction: the poll loop never completes, or reads a stale flag.
- Turnaround released one bit late or early: the enable pattern differs at bit 46.
- Data sampled on the wrong MDC edge: the read data comes back shifted by one bit.
- Reserved bits 30:24 not masked: they read back nonzero.
- Register field taken from the wrong address bits: the frame differs whenever bits 23:21 are nonzero.
- A mid-frame strobe accepted: the read-back word changes or the frame is corrupted.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] TA_CODE  = 2'b10;

  // Host-visible access word.
  typedef struct packed {
    logic        flag;
    logic [6:0]  rsvd;
    logic [7:0]  regsel;
    logic [15:0] data;
  } acc_word_t;

  // Full serial frame, bit 63 leaves first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        is_wr,
    input logic [4:0]  phy,
    input logic [4:0]  regf,
    input logic [15:0] d
  );
    build_frame = {{PRE_BITS{1'b1}}, SOF_CODE, (is_wr ? OP_WRITE : OP_READ),
                   phy, regf, TA_CODE, d};
  endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rise_tick = en & wrap & ~mdc;
  assign fall_tick = en & wrap & mdc;

  // R8: clock parks low once the engine stops requesting it
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import phy_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_wr,
  input  logic [4:0]  start_reg,
  input  logic [15:0] start_data,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        busy_read,
  output logic        complete,
  output logic [15:0] rd_word,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] shreg;
  logic                  rd_mode;
  logic [15:0]           cap;
  logic                  last_bit;
  logic                  in_data;
  logic                  released;

  assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
  assign in_data  = (idx >= IDX_W'(DATA_IDX));
  assign released = rd_mode & (idx >= IDX_W'(TA_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      shreg   <= '1;
      rd_mode <= 1'b0;
      cap     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        shreg   <= build_frame(start_wr, PHY_ADDR, start_reg, start_data);
        rd_mode <= ~start_wr;
        cap     <= '0;
      end
    end else begin
      if (rise_tick && rd_mode && in_data)
        cap <= {cap[14:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  assign complete  = busy & fall_tick & last_bit;
  assign busy_read = busy & rd_mode;
  assign rd_word   = cap;
  assign mdio_o    = busy ? shreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe   = busy & ~released;

  // R6: a finishing read never leaves the line driven
  p_read_ends_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && rd_mode) |-> !mdio_oe);

endmodule

// File: rtl/phy_acc_reg.sv
module phy_acc_reg
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        eng_busy,
  input  logic        complete,
  input  logic [15:0] rd_word,
  output logic [31:0] rd_data,
  output logic        start,
  output logic        start_wr,
  output logic [4:0]  start_reg,
  output logic [15:0] start_data
);
  acc_word_t acc;
  logic      accept;
  logic      unused_rsvd;

  assign accept      = wr_en & ~eng_busy;
  assign unused_rsvd = ^wr_data[30:24];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (accept) begin
      acc.flag   <= wr_data[31];
      acc.rsvd   <= '0;
      acc.regsel <= wr_data[23:16];
      acc.data   <= wr_data[15:0];
    end else if (complete) begin
      if (acc.flag) begin
        acc.flag <= 1'b0;
      end else begin
        acc.flag <= 1'b1;
        acc.data <= rd_word;
      end
    end
  end

  assign rd_data    = acc;
  assign start      = accept;
  assign start_wr   = wr_data[31];
  assign start_reg  = wr_data[20:16];
  assign start_data = wr_data[15:0];

  // R9: strobes during a running frame leave the word untouched
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && wr_en && !complete) |=> $stable(rd_data));

endmodule

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port #(
  parameter int         MDC_HALF = 2,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        start, start_wr;
  logic [4:0]  start_reg;
  logic [15:0] start_data;
  logic        eng_busy, eng_busy_rd, complete;
  logic [15:0] rd_word;
  logic        rise_tick, fall_tick;

  phy_acc_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr),
    .wr_data    (host_wdata),
    .eng_busy   (eng_busy),
    .complete   (complete),
    .rd_word    (rd_word),
    .rd_data    (host_rdata),
    .start      (start),
    .start_wr   (start_wr),
    .start_reg  (start_reg),
    .start_data (start_data)
  );

  mdio_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_wr   (start_wr),
    .start_reg  (start_reg),
    .start_data (start_data),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdio_i     (mdio_i),
    .busy       (eng_busy),
    .busy_read  (eng_busy_rd),
    .complete   (complete),
    .rd_word    (rd_word),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  mdc_divider #(.HALF(MDC_HALF)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (eng_busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  // R7: data never moves on the rising management clock edge
  p_edge_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o));

  // R2: a running write shows flag 1
  p_wr_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !eng_busy_rd) |-> host_rdata[31]);

  // R3: a running read shows flag 0
  p_rd_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy_rd |-> !host_rdata[31]);

  // R1: enable is low whenever no frame runs
  p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !mdio_oe);

endmodule

// File: tb/phy_mgmt_port_bench.sv
module phy_mgmt_port_bench;
  localparam int         HALF = 2;
  localparam logic [4:0] PHY  = 5'h1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  phy_mgmt_port #(.MDC_HALF(HALF), .PHY_ADDR(PHY)) u_phy_mgmt_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // Behavioural PHY
  int          pos_cnt = 0;
  int          neg_cnt = 0;
  logic [63:0] cap_o  = '0;
  logic [63:0] cap_oe = '0;
  logic [15:0] phy_resp = '0;
  time         last_rise = 0;
  time         period = 0;

  always @(posedge mdc) begin
    if (pos_cnt < 64) begin
      cap_o[63 - pos_cnt]  = mdio_o;
      cap_oe[63 - pos_cnt] = mdio_oe;
    end
    pos_cnt = pos_cnt + 1;
    if (last_rise != 0) period = $time - last_rise;
    last_rise = $time;
  end

  always @(negedge mdc) neg_cnt = neg_cnt + 1;

  assign mdio_i = (neg_cnt >= 48 && neg_cnt < 64) ? phy_resp[4'(63 - neg_cnt)] : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [31:0] w, input logic [15:0] resp, input bit poke);
    logic [63:0] exp;
    logic [31:0] held;
    bit          done;
    phy_resp  = resp;
    pos_cnt   = 0;
    neg_cnt   = 0;
    last_rise = 0;
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
    held = {w[31], 7'd0, w[23:0]};
    // R4: reserved bits cleared, 8-bit register field kept; R2/R3 pending flag
    chk(host_rdata == held, w[31] ? "R2/R4 pending" : "R3/R4 pending",
        64'(host_rdata), 64'(held));
    if (poke) begin
      repeat (20) @(negedge clk);
      host_wr = 1'b1;
      host_wdata = ~w;
      @(negedge clk);
      host_wr = 1'b0;
      @(negedge clk);
      chk(host_rdata == held, "R9 ignored strobe", 64'(host_rdata), 64'(held));
    end
    done = 1'b0;
    for (int i = 0; i < 4000 && !done; i++) begin
      @(negedge clk);
      if (host_rdata[31] != w[31]) done = 1'b1;
    end
    chk(done, "R2/R3 completion", 64'(host_rdata), 64'(held));
    exp = {32'hFFFF_FFFF, 2'b01, (w[31] ? 2'b01 : 2'b10), PHY, w[20:16], 2'b10, w[15:0]};
    chk(pos_cnt == 64, "R5 frame length", 64'(pos_cnt), 64'd64);
    chk(period == time'(2 * HALF * 10), "R8 MDC period", 64'(period), 64'(2 * HALF * 10));
    chk(!mdc && !mdio_oe, "R8 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    if (w[31]) begin
      chk(cap_o == exp, "R5 write frame", cap_o, exp);
      chk(cap_oe == '1, "R5 write enable", cap_oe, '1);
      chk(host_rdata == {1'b0, 7'd0, w[23:0]}, "R2 write done",
          64'(host_rdata), 64'({1'b0, 7'd0, w[23:0]}));
    end else begin
      chk(cap_o[63:18] == exp[63:18], "R6 read header",
          64'(cap_o[63:18]), 64'(exp[63:18]));
      chk(cap_oe == {{46{1'b1}}, 18'd0}, "R6 turnaround release",
          cap_oe, {{46{1'b1}}, 18'd0});
      chk(host_rdata == {1'b1, 7'd0, w[23:16], resp}, "R3 read data",
          64'(host_rdata), 64'({1'b1, 7'd0, w[23:16], resp}));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(host_rdata == 32'd0 && !mdc && !mdio_oe, "R1 reset",
        {host_rdata, 30'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rdata == 32'd0 && !mdc && !mdio_oe, "R1 after release",
        {host_rdata, 30'd0, mdc, mdio_oe}, 64'd0);
    for (int r = 0; r < 32; r++) begin
      logic [7:0]  ra;
      logic [15:0] d;
      ra = {3'(r * 5), 5'(r)};
      d  = 16'(r * 16'h1357) ^ 16'hC0DE;
      txn({1'b1, 7'h7F, ra, d}, 16'h0000, (r % 8) == 3);
      txn({1'b0, 7'(r), ra, 16'hFFFF}, ~d, (r % 8) == 5);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    tests++;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule